// File: doc/BRIEF.md
# UART Status and Interrupt Flag Unit

This block gathers the condition signals of a serial port (event pulses from the receiver, occupancy levels of the transmit and receive queues, the shift-register idle indication and the clear-to-send pin) and turns them into one 32-bit status word. Each defined bit of that word can raise an interrupt. The serial shifters and the queue storage sit outside the block; their state reaches it only through input ports.

Two kinds of flag share the word. Event flags latch on a one-cycle pulse and stay set until software writes 1 to their bit position. Level flags follow the queue occupancy against programmable thresholds, or clear on queue activity, and ignore writes. A small register port reads the status, clears event flags and loads a per-flag interrupt enable mask. The clear-to-send pin is active low. It passes through a two-stage synchroniser, and an edge detector after the synchroniser records every change of the pin.

Top module: `uart_flag_unit`

## Requirements
- R1: While reset is held, and right after it, the status word reads 0. Bits 31..12 and 1..0 always read 0. Register address 0 selects status and address 1 selects the enable mask. Any other address reads 0.
- R2: Bit 11 reads 1 when the clear-to-send pin is low. A pin change applied between edges shows up after the second following clock edge.
- R3: Bit 10 sets one edge after bit 11 changes, for both rising and falling pin transitions. It stays set until 1 is written to bit 10 at address 0.
- R4: Bits 9 (address match), 4 (line break), 3 (framing error) and 2 (parity error) set on their event pulse and hold. Writing 1 to a bit at address 0 clears it; writing 0 leaves it unchanged.
- R5: When an event pulse and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R6: Bit 8 is 1 after an edge at which the transmit level was 0, the shift register was idle and no data-register write strobe was present; otherwise it is 0. Writes to bit 8 have no effect.
- R7: Bit 7 is 1 after an edge at which the transmit level was below the transmit threshold, and 0 otherwise.
- R8: Bit 5 is 1 after an edge at which the receive level was greater than or equal to the receive threshold, and 0 otherwise.
- R9: Bit 6 sets on a receive-timeout pulse and holds. It clears at an edge where the receive level is 0, and that clear takes priority over a pulse in the same cycle. Writes to bit 6 have no effect.
- R10: A write to address 1 loads the enable mask. Only bits 11..2 are stored. irqVec equals status AND mask, and irq is high exactly when irqVec is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register address (0 status, 1 enable) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| ctsPinN | input | 1 | Clear-to-send pin, active low, asynchronous |
| evAddrMatch | input | 1 | Pulse: receiver matched its node address |
| evBreak | input | 1 | Pulse: line break detected |
| evFrameErr | input | 1 | Pulse: bad stop bit |
| evParityErr | input | 1 | Pulse: bad parity bit |
| evRxTimeout | input | 1 | Pulse: receive queue idle timeout |
| dataWrStrobe | input | 1 | Pulse: data register written with new transmit data |
| txShiftEmpty | input | 1 | Transmit shift register idle |
| txLevel | input | LVL_W | Transmit queue occupancy |
| txThresh | input | LVL_W | Transmit threshold |
| rxLevel | input | LVL_W | Receive queue occupancy |
| rxThresh | input | LVL_W | Receive threshold |
| statusWord | output | 32 | Status word |
| irqVec | output | 32 | Per-flag interrupt requests |
| irq | output | 1 | Combined interrupt |

## Verification
The collision that matters is an event pulse and a write-1 clear of the same flag arriving together. The bench drives every combination of the four event pulses against every combination of clear bits in the same cycle, so each flag meets set-only, clear-only, both and neither, starting from both prior states, and the result is judged against a model that gives set the win. A second collision is a receive-timeout pulse in a cycle where the receive level is 0, which must resolve as clear. A third is a data-register write strobe in a cycle where the transmit path is idle, which must hold bit 8 at 0.

// File: rtl/uflag_pkg.sv
`timescale 1ns/1ps
package uflag_pkg;
  localparam int STAT_W = 32;

  localparam int BIT_PAR    = 2;
  localparam int BIT_FRM    = 3;
  localparam int BIT_BRK    = 4;
  localparam int BIT_RXRDY  = 5;
  localparam int BIT_RXTO   = 6;
  localparam int BIT_TXLOW  = 7;
  localparam int BIT_TXDONE = 8;
  localparam int BIT_ADDR   = 9;
  localparam int BIT_CTSCHG = 10;
  localparam int BIT_CTSACT = 11;

  // every defined flag position
  localparam logic [STAT_W-1:0] FLAG_MASK = 32'h0000_0FFC;
  // flags that latch and clear by writing 1
  localparam logic [STAT_W-1:0] W1C_MASK  = 32'h0000_061C;

  typedef struct packed {
    logic [STAT_W-1:0] clrMask;   // write-1 clear request, already masked
    logic              enWr;      // load enable register
    logic [STAT_W-1:0] enVal;     // value for enable register
    logic              ctsActive; // synchronised pin is low
    logic              ctsEdge;   // synchronised pin changed
  } ctrl_strobe_t;
endpackage

// File: rtl/uflag_ctrl.sv
`timescale 1ns/1ps
module uflag_ctrl
  import uflag_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [STAT_W-1:0] busWdata,
  input  logic              ctsPinN,
  input  logic [STAT_W-1:0] statusWord,
  input  logic [STAT_W-1:0] enableWord,
  output logic [STAT_W-1:0] busRdata,
  output ctrl_strobe_t      strobe
);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_EN   = ADDR_W'(1);

  logic ctsMeta, ctsSync, ctsPrev;
  logic wrStat, wrEn;

  // two-stage synchroniser plus one history stage; idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsMeta <= 1'b1;
      ctsSync <= 1'b1;
      ctsPrev <= 1'b1;
    end else begin
      ctsMeta <= ctsPinN;
      ctsSync <= ctsMeta;
      ctsPrev <= ctsSync;
    end
  end

  assign wrStat = busSel && busWr && (busAddr == ADDR_STAT);
  assign wrEn   = busSel && busWr && (busAddr == ADDR_EN);

  always_comb begin
    strobe.clrMask   = wrStat ? (busWdata & W1C_MASK) : '0;
    strobe.enWr      = wrEn;
    strobe.enVal     = busWdata & FLAG_MASK;
    strobe.ctsActive = ~ctsSync;
    strobe.ctsEdge   = ctsSync ^ ctsPrev;
  end

  always_comb begin
    busRdata = '0;
    if (busSel && !busWr) begin
      if (busAddr == ADDR_STAT)    busRdata = statusWord;
      else if (busAddr == ADDR_EN) busRdata = enableWord;
    end
  end

  // enable register never holds bits outside the flag field
  assert_enable_field_R10: assert property (@(posedge clk) disable iff (!rstN)
    (enableWord & ~FLAG_MASK) == '0);

  // undefined status positions stay zero
  assert_status_field_R1: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord & ~FLAG_MASK) == '0);

  // status bit follows synchronised pin once reset is gone
  assert_cts_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[BIT_CTSACT] == ~ctsSync);
endmodule

// File: rtl/uflag_datapath.sv
`timescale 1ns/1ps
module uflag_datapath
  import uflag_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic              evAddrMatch,
  input  logic              evBreak,
  input  logic              evFrameErr,
  input  logic              evParityErr,
  input  logic              evRxTimeout,
  input  logic              dataWrStrobe,
  input  logic              txShiftEmpty,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  txThresh,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [LVL_W-1:0]  rxThresh,
  output logic [STAT_W-1:0] statusWord,
  output logic [STAT_W-1:0] enableWord,
  output logic [STAT_W-1:0] irqVec,
  output logic              irq
);
  logic [STAT_W-1:0] setVec;
  logic [STAT_W-1:0] stickyQ;
  logic txDoneQ, txLowQ, rxRdyQ, rxToQ;
  logic [STAT_W-1:0] enableQ;
  logic txIdle, rxEmpty;

  always_comb begin
    setVec             = '0;
    setVec[BIT_PAR]    = evParityErr;
    setVec[BIT_FRM]    = evFrameErr;
    setVec[BIT_BRK]    = evBreak;
    setVec[BIT_ADDR]   = evAddrMatch;
    setVec[BIT_CTSCHG] = strobe.ctsEdge;
  end

  // sticky flags: set has priority over a write-1 clear
  for (genvar i = 0; i < STAT_W; i++) begin : g_flag
    if (W1C_MASK[i]) begin : g_sticky
      logic q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= 1'b0;
        else       q <= setVec[i] | (q & ~strobe.clrMask[i]);
      end
      assign stickyQ[i] = q;

      assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
        setVec[i] |=> q);
      assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
        (q && !strobe.clrMask[i]) |=> q);
    end else begin : g_plain
      assign stickyQ[i] = 1'b0;
    end
  end

  assign txIdle  = (txLevel == '0) && txShiftEmpty;
  assign rxEmpty = (rxLevel == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txDoneQ <= 1'b0;
      txLowQ  <= 1'b0;
      rxRdyQ  <= 1'b0;
      rxToQ   <= 1'b0;
      enableQ <= '0;
    end else begin
      txDoneQ <= txIdle && !dataWrStrobe;
      txLowQ  <= (txLevel < txThresh);
      rxRdyQ  <= (rxLevel >= rxThresh);
      rxToQ   <= rxEmpty ? 1'b0 : (rxToQ | evRxTimeout);
      if (strobe.enWr) enableQ <= strobe.enVal;
    end
  end

  always_comb begin
    statusWord             = stickyQ;
    statusWord[BIT_TXDONE] = txDoneQ;
    statusWord[BIT_TXLOW]  = txLowQ;
    statusWord[BIT_RXRDY]  = rxRdyQ;
    statusWord[BIT_RXTO]   = rxToQ;
    statusWord[BIT_CTSACT] = strobe.ctsActive;
  end

  assign enableWord = enableQ;
  assign irqVec     = statusWord & enableQ;
  assign irq        = |irqVec;

  assert_txdone_wr_R6: assert property (@(posedge clk) disable iff (!rstN)
    dataWrStrobe |=> !statusWord[BIT_TXDONE]);
  assert_rxto_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxEmpty |=> !statusWord[BIT_RXTO]);
  assert_txlow_track_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel < txThresh) |=> statusWord[BIT_TXLOW]);
  assert_rxrdy_track_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel < rxThresh) |=> !statusWord[BIT_RXRDY]);
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == '0) |-> !irq);
endmodule

// File: rtl/uart_flag_unit.sv
`timescale 1ns/1ps
module uart_flag_unit
  import uflag_pkg::*;
#(
  parameter int LVL_W  = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              ctsPinN,
  input  logic              evAddrMatch,
  input  logic              evBreak,
  input  logic              evFrameErr,
  input  logic              evParityErr,
  input  logic              evRxTimeout,
  input  logic              dataWrStrobe,
  input  logic              txShiftEmpty,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  txThresh,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [LVL_W-1:0]  rxThresh,
  output logic [31:0]       statusWord,
  output logic [31:0]       irqVec,
  output logic              irq
);
  ctrl_strobe_t      strobe;
  logic [STAT_W-1:0] enableWord;

  uflag_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .ctsPinN(ctsPinN),
    .statusWord(statusWord), .enableWord(enableWord),
    .busRdata(busRdata), .strobe(strobe)
  );

  uflag_datapath #(.LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .evAddrMatch(evAddrMatch), .evBreak(evBreak), .evFrameErr(evFrameErr),
    .evParityErr(evParityErr), .evRxTimeout(evRxTimeout),
    .dataWrStrobe(dataWrStrobe), .txShiftEmpty(txShiftEmpty),
    .txLevel(txLevel), .txThresh(txThresh), .rxLevel(rxLevel), .rxThresh(rxThresh),
    .statusWord(statusWord), .enableWord(enableWord), .irqVec(irqVec), .irq(irq)
  );
endmodule

// File: tb/tb_uart_flag_unit.sv
`timescale 1ns/1ps
module tb_uart_flag_unit;
  localparam int LVL_W  = 3;
  localparam int ADDR_W = 2;
  localparam int LMAX   = 1 << LVL_W;
  localparam logic [31:0] FMASK = 32'h0000_0FFC;
  localparam logic [31:0] WMASK = 32'h0000_061C;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic busSel, busWr;
  logic [ADDR_W-1:0] busAddr;
  logic [31:0] busWdata, busRdata, statusWord, irqVec;
  logic irq;
  logic ctsPinN, evAddrMatch, evBreak, evFrameErr, evParityErr, evRxTimeout;
  logic dataWrStrobe, txShiftEmpty;
  logic [LVL_W-1:0] txLevel, txThresh, rxLevel, rxThresh;

  uart_flag_unit #(.LVL_W(LVL_W), .ADDR_W(ADDR_W)) dut (.*);

  int nCmp = 0, nBad = 0;
  bit done = 0;

  // bench model
  logic [31:0] mSticky = '0, mEn = '0;
  logic mTxDone = 0, mTxLow = 0, mRxRdy = 0, mRxTo = 0;
  logic mM = 1, mS = 1, mP = 1;

  function automatic logic [31:0] expStatus();
    logic [31:0] v;
    v = mSticky;
    v[8] = mTxDone; v[7] = mTxLow; v[6] = mRxTo; v[5] = mRxRdy; v[11] = ~mS;
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: model advances from current inputs, pulses then drop
  task automatic step();
    logic [31:0] setV, clrV;
    setV = '0;
    setV[2] = evParityErr; setV[3] = evFrameErr; setV[4] = evBreak;
    setV[9] = evAddrMatch; setV[10] = mS ^ mP;
    clrV = (busSel && busWr && busAddr == 0) ? (busWdata & WMASK) : '0;
    mSticky = (setV | (mSticky & ~clrV)) & WMASK;
    mTxDone = (int'(txLevel) == 0) && txShiftEmpty && !dataWrStrobe;
    mTxLow  = int'(txLevel) < int'(txThresh);
    mRxRdy  = int'(rxLevel) >= int'(rxThresh);
    mRxTo   = (int'(rxLevel) == 0) ? 1'b0 : (mRxTo | evRxTimeout);
    if (busSel && busWr && busAddr == 1) mEn = busWdata & FMASK;
    mP = mS; mS = mM; mM = ctsPinN;
    @(posedge clk);
    @(negedge clk);
    busSel = 0; busWr = 0; busWdata = '0; busAddr = '0;
    evAddrMatch = 0; evBreak = 0; evFrameErr = 0; evParityErr = 0;
    evRxTimeout = 0; dataWrStrobe = 0;
  endtask

  task automatic checkAll(string tag);
    logic [31:0] e;
    e = expStatus();
    busSel = 1; busWr = 0; busAddr = 0;
    #1;
    chk(tag, busRdata, e);
    chk({tag, " irqVec R10"}, irqVec, e & mEn);
    chk({tag, " irq R10"}, {31'b0, irq}, {31'b0, |(e & mEn)});
    busSel = 0;
  endtask

  task automatic busWrite(int a, logic [31:0] d);
    busSel = 1; busWr = 1; busAddr = ADDR_W'(a); busWdata = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++; nCmp++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 0; busSel = 0; busWr = 0; busAddr = '0; busWdata = '0;
    ctsPinN = 1; evAddrMatch = 0; evBreak = 0; evFrameErr = 0; evParityErr = 0;
    evRxTimeout = 0; dataWrStrobe = 0; txShiftEmpty = 1;
    txLevel = '0; txThresh = '0; rxLevel = '0; rxThresh = 3'd1;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkAll("R1 reset");
    rstN = 1;
    busSel = 1; busAddr = 2'd2; #1; chk("R1 unmapped read", busRdata, '0);
    busAddr = 2'd3; #1; chk("R1 unmapped read", busRdata, '0); busSel = 0;

    // R10: enable everything so irq paths are exercised too
    busWrite(1, 32'hFFFF_FFFF); step();
    busSel = 1; busAddr = 2'd1; #1; chk("R10 enable readback", busRdata, FMASK); busSel = 0;
    checkAll("R1 after reset");

    // R6 R7: sweep transmit level, threshold, shift state and write strobe
    for (int t = 0; t < LMAX; t++)
      for (int l = 0; l < LMAX; l++)
        for (int k = 0; k < 4; k++) begin
          txThresh = LVL_W'(t); txLevel = LVL_W'(l);
          txShiftEmpty = k[0]; dataWrStrobe = k[1];
          step(); checkAll("R6 R7 tx sweep");
        end

    // R6 R9: write-1 to level bits has no effect
    txLevel = '0; txShiftEmpty = 1; rxLevel = 3'd2; evRxTimeout = 1; step();
    busWrite(0, 32'h0000_01E0); step(); checkAll("R6 R9 write ignored");

    // R8 R9: sweep receive level and threshold with timeout pulses
    for (int t = 0; t < LMAX; t++)
      for (int l = 0; l < LMAX; l++)
        for (int k = 0; k < 2; k++) begin
          rxThresh = LVL_W'(t); rxLevel = LVL_W'(l); evRxTimeout = k[0];
          step(); checkAll("R8 R9 rx sweep");
        end
    // R9: pulse with empty queue resolves as clear
    rxLevel = 3'd4; evRxTimeout = 1; step(); checkAll("R9 timeout set");
    rxLevel = '0; evRxTimeout = 1; step(); checkAll("R9 empty beats pulse");

    // R4 R5: every set pattern against every clear pattern, same cycle
    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 16; c++) begin
        logic [31:0] cw;
        evParityErr = s[0]; evFrameErr = s[1]; evBreak = s[2]; evAddrMatch = s[3];
        cw = '0; cw[2] = c[0]; cw[3] = c[1]; cw[4] = c[2]; cw[9] = c[3];
        busWrite(0, cw);
        step(); checkAll("R4 R5 sticky matrix");
        step(); checkAll("R4 sticky hold");
      end

    // R2 R3: clear-to-send transitions, checked every cycle
    for (int n = 0; n < 6; n++) begin
      ctsPinN = ~ctsPinN;
      for (int w = 0; w < 4; w++) begin step(); checkAll("R2 R3 cts"); end
      busWrite(0, 32'h0000_0400); step(); checkAll("R3 cts clear");
    end
    // R5 on change flag: clear in the cycle the edge lands
    ctsPinN = ~ctsPinN; step(); step();
    busWrite(0, 32'h0000_0400); step(); checkAll("R5 cts set beats clear");

    // R10: walk enable patterns
    for (int b = 0; b < 12; b++) begin
      busWrite(1, 32'h1 << b); step(); checkAll("R10 enable walk");
    end
    busWrite(1, 32'h0); step(); checkAll("R10 all masked");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule